// File: doc/BRIEF.md
# Line-Doubling Scan Controller

This block sequences a pointer-reset line buffer so that interlaced video can be shown progressively. It runs on a clock at twice the input pixel rate. Each incoming line goes into the buffer at half rate: the write strobe is granted on alternate clocks only. Each stored line is then read back twice at the full clock rate. As a result, the line stored before serves as the interpolated line between two real ones.

The controller counts positions within the input line and within the output line. From those counts it decodes the following strobes, all active low:

- a write enable and a write pointer restart, shared by every buffer;
- a read enable, a read pointer restart and an output enable for each buffer.

With one buffer, that buffer is read in both output lines. With two buffers, the buffer that reads alternates every output line. This lets a second buffer holding separately prepared interpolated data supply every other output line.

A line-start pulse marks input position 0. The counters also wrap by themselves at the programmed line lengths. Near the end of the second read of a line, the read pointer catches up with the write pointer closer than the buffer's minimum write-to-read distance. A flag marks those output words, because they may still hold the line before.

Top module: `scan_doubler_ctl`

## Requirements
- R1: After reset and until the first line-start pulse, every strobe output is high (inactive), `tail_stale` is 0, and both position counters read 0.
- R2: A line-start pulse sampled at a clock edge sets `in_pix` to 0 for the following cycle. Without a pulse, `in_pix` counts up by one per clock and wraps from IN_LINE-1 to 0.
- R3: `out_pix` counts 0..OUT_LINE-1 twice per input line, with IN_LINE equal to 2*OUT_LINE. `out_half` is 0 during the first output line and 1 during the second.
- R4: Once running, `wr_en_n` is low exactly when `in_pix` is even, so writes happen at half the clock rate.
- R5: Once running, `wr_rst_n` is low exactly when `in_pix` is 0, which is once per input line.
- R6: The read restart of the active buffer is low exactly when `out_pix` is 0, which is twice per input line.
- R7: With NUM_BUF = 1, once running, `rd_en_n[0]` and `oe_n[0]` stay low in both output lines.
- R8: With NUM_BUF = 2, buffer index `out_half` is active: its `rd_en_n` and `oe_n` bits are low. The other buffer has `rd_en_n`, `rd_rst_n` and `oe_n` all high. At most one buffer is ever enabled.
- R9: `tail_stale` is 1 exactly when running, `out_half` is 1 and `out_pix` > OUT_LINE-2*MIN_GAP.
- R10: A line-start pulse in mid-line restarts `in_pix`, `out_pix` and `out_half` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffer clock, twice the input pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sol | input | 1 | Start-of-input-line pulse; next cycle is position 0 |
| in_pix | output | $clog2(IN_LINE) | Position within the input line |
| out_pix | output | $clog2(OUT_LINE) | Position within the output line |
| out_half | output | 1 | Which output line of the pair is in progress |
| wr_en_n | output | 1 | Write enable, active low, shared |
| wr_rst_n | output | 1 | Write pointer restart, active low, shared |
| rd_en_n | output | NUM_BUF | Read enable per buffer, active low |
| rd_rst_n | output | NUM_BUF | Read pointer restart per buffer, active low |
| oe_n | output | NUM_BUF | Output enable per buffer, active low |
| tail_stale | output | 1 | Current output word may still be preceding-line data |

## Verification
The properties assume the line-start pulse is a single-cycle event. They also assume IN_LINE is even, so that the parity of the write strobe survives a natural wrap. Consecutive write grants are excused only in the cycle after a pulse lands on an even position. The stimulus issues single-cycle pulses. One lands at a full line boundary; the other lands mid-line on an odd position, so the write cadence stays intact. Two instances share that stimulus, one per buffer count, so both generate variants see the same pulses.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

   // per-buffer read-side control, active high inside the block
   typedef struct packed {
      logic rd_en;
      logic rd_rst;
      logic oe;
   } rd_ctl_t;

   function automatic int stale_threshold(input int out_line, input int min_gap);
      return out_line - 2 * min_gap;
   endfunction

endpackage

// File: rtl/dbl_line_timer.sv
module dbl_line_timer #(
   parameter int IN_LINE  = 1820,
   parameter int OUT_LINE = 910,
   localparam int IW = $clog2(IN_LINE),
   localparam int OW = $clog2(OUT_LINE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sol,
   output logic          run,
   output logic [IW-1:0] in_pix,
   output logic [OW-1:0] out_pix,
   output logic          half
);

   localparam logic [IW-1:0] IN_LAST  = IW'(IN_LINE - 1);
   localparam logic [OW-1:0] OUT_LAST = OW'(OUT_LINE - 1);

   logic out_wrap;
   assign out_wrap = (out_pix == OUT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
      end else if (sol) begin
         run <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pix <= '0;
      end else if (sol) begin
         in_pix <= '0;
      end else if (run) begin
         in_pix <= (in_pix == IN_LAST) ? '0 : in_pix + IW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pix <= '0;
         half    <= 1'b0;
      end else if (sol) begin
         out_pix <= '0;
         half    <= 1'b0;
      end else if (run) begin
         out_pix <= out_wrap ? '0 : out_pix + OW'(1);
         if (out_wrap) begin
            half <= ~half;
         end
      end
   end

endmodule

// File: rtl/dbl_write_gen.sv
module dbl_write_gen #(
   parameter int IN_LINE = 1820,
   localparam int IW = $clog2(IN_LINE)
) (
   input  logic          run,
   input  logic [IW-1:0] in_pix,
   output logic          wr_en_n,
   output logic          wr_rst_n
);

   // a write on every even position: one write per input pixel
   always_comb begin
      wr_en_n  = ~(run & ~in_pix[0]);
      wr_rst_n = ~(run & (in_pix == '0));
   end

endmodule

// File: rtl/dbl_read_gen.sv
module dbl_read_gen
   import dbl_pkg::*;
#(
   parameter int NUM_BUF  = 2,
   parameter int OUT_LINE = 910,
   parameter int MIN_GAP  = 21,
   localparam int OW = $clog2(OUT_LINE),
   localparam int THR = stale_threshold(OUT_LINE, MIN_GAP)
) (
   input  logic               run,
   input  logic [OW-1:0]      out_pix,
   input  logic               half,
   output logic [NUM_BUF-1:0] rd_en_n,
   output logic [NUM_BUF-1:0] rd_rst_n,
   output logic [NUM_BUF-1:0] oe_n,
   output logic               tail_stale
);

   rd_ctl_t ctl [NUM_BUF];
   logic    line_top;

   assign line_top   = (out_pix == '0);
   assign tail_stale = run & half & (int'(out_pix) > THR);

   generate
      if (NUM_BUF == 1) begin : g_single
         // the lone buffer is read in both output lines
         always_comb begin
            ctl[0].rd_en  = run;
            ctl[0].oe     = run;
            ctl[0].rd_rst = run & line_top;
         end
      end else begin : g_pingpong
         for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
            logic mine;
            assign mine = run & (half == b[0]);
            always_comb begin
               ctl[b].rd_en  = mine;
               ctl[b].oe     = mine;
               ctl[b].rd_rst = mine & line_top;
            end
         end
      end

      for (genvar b = 0; b < NUM_BUF; b++) begin : g_out
         assign rd_en_n[b]  = ~ctl[b].rd_en;
         assign rd_rst_n[b] = ~ctl[b].rd_rst;
         assign oe_n[b]     = ~ctl[b].oe;
      end
   endgenerate

endmodule

// File: rtl/scan_doubler_ctl.sv
module scan_doubler_ctl #(
   parameter int NUM_BUF  = 2,
   parameter int OUT_LINE = 910,
   parameter int IN_LINE  = 1820,
   parameter int MIN_GAP  = 21,
   localparam int IW = $clog2(IN_LINE),
   localparam int OW = $clog2(OUT_LINE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_sol,
   output logic [IW-1:0]      in_pix,
   output logic [OW-1:0]      out_pix,
   output logic               out_half,
   output logic               wr_en_n,
   output logic               wr_rst_n,
   output logic [NUM_BUF-1:0] rd_en_n,
   output logic [NUM_BUF-1:0] rd_rst_n,
   output logic [NUM_BUF-1:0] oe_n,
   output logic               tail_stale
);

   generate
      if (NUM_BUF < 1 || NUM_BUF > 2) begin : g_bad_nbuf
         $error("scan_doubler_ctl: NUM_BUF must be 1 or 2");
      end
      if (IN_LINE != 2 * OUT_LINE) begin : g_bad_ratio
         $error("scan_doubler_ctl: IN_LINE must be twice OUT_LINE");
      end
      if (OUT_LINE < 2 || 2 * MIN_GAP >= OUT_LINE) begin : g_bad_gap
         $error("scan_doubler_ctl: MIN_GAP too large for OUT_LINE");
      end
   endgenerate

   logic run;

   dbl_line_timer #(
      .IN_LINE (IN_LINE),
      .OUT_LINE(OUT_LINE)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .sol    (line_sol),
      .run    (run),
      .in_pix (in_pix),
      .out_pix(out_pix),
      .half   (out_half)
   );

   dbl_write_gen #(
      .IN_LINE(IN_LINE)
   ) u_wr (
      .run     (run),
      .in_pix  (in_pix),
      .wr_en_n (wr_en_n),
      .wr_rst_n(wr_rst_n)
   );

   dbl_read_gen #(
      .NUM_BUF (NUM_BUF),
      .OUT_LINE(OUT_LINE),
      .MIN_GAP (MIN_GAP)
   ) u_rd (
      .run       (run),
      .out_pix   (out_pix),
      .half      (out_half),
      .rd_en_n   (rd_en_n),
      .rd_rst_n  (rd_rst_n),
      .oe_n      (oe_n),
      .tail_stale(tail_stale)
   );

endmodule

// File: rtl/dbl_checker.sv
module dbl_checker #(
   parameter int NUM_BUF  = 2,
   parameter int OUT_LINE = 910,
   parameter int IN_LINE  = 1820,
   parameter int MIN_GAP  = 21,
   localparam int IW = $clog2(IN_LINE),
   localparam int OW = $clog2(OUT_LINE)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               line_sol,
   input logic               run,
   input logic [IW-1:0]      in_pix,
   input logic [OW-1:0]      out_pix,
   input logic               out_half,
   input logic               wr_en_n,
   input logic               wr_rst_n,
   input logic [NUM_BUF-1:0] rd_en_n,
   input logic [NUM_BUF-1:0] rd_rst_n,
   input logic [NUM_BUF-1:0] oe_n,
   input logic               tail_stale
);

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (wr_en_n && wr_rst_n && (&rd_en_n) && (&oe_n) && !tail_stale));

   p_in_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !line_sol && in_pix != IW'(IN_LINE - 1)) |=> in_pix == $past(in_pix) + IW'(1));

   p_out_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !line_sol && out_pix == OW'(OUT_LINE - 1)) |=> (out_pix == '0 && out_half != $past(out_half)));

   p_wr_pace_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_n && !line_sol) |=> wr_en_n);

   p_wr_rst_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rst_n |-> !wr_en_n);

   p_rd_rst_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (~rd_rst_n != '0) |-> out_pix == '0);

   p_one_reader_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~rd_en_n));

   p_stale_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tail_stale |-> out_half);

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      line_sol |=> (in_pix == '0 && out_pix == '0 && !out_half));

endmodule

bind scan_doubler_ctl dbl_checker #(
   .NUM_BUF (NUM_BUF),
   .OUT_LINE(OUT_LINE),
   .IN_LINE (IN_LINE),
   .MIN_GAP (MIN_GAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_sol  (line_sol),
   .run       (run),
   .in_pix    (in_pix),
   .out_pix   (out_pix),
   .out_half  (out_half),
   .wr_en_n   (wr_en_n),
   .wr_rst_n  (wr_rst_n),
   .rd_en_n   (rd_en_n),
   .rd_rst_n  (rd_rst_n),
   .oe_n      (oe_n),
   .tail_stale(tail_stale)
);

// File: tb/test_scan_doubler_ctl.sv
`timescale 1ns/1ps
module test_scan_doubler_ctl;

   localparam int OL = 10;
   localparam int IL = 20;
   localparam int GAP = 3;
   localparam int IW = $clog2(IL);
   localparam int OW = $clog2(OL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sol = 1'b0;

   always #4 clk = ~clk;

   logic [IW-1:0] in2, in1;
   logic [OW-1:0] out2, out1;
   logic          h2, h1, we2, we1, wr2, wr1, st2, st1;
   logic [1:0]    re2, rr2, oe2;
   logic [0:0]    re1, rr1, oe1;

   scan_doubler_ctl #(.NUM_BUF(2), .OUT_LINE(OL), .IN_LINE(IL), .MIN_GAP(GAP)) i_scan_doubler_ctl (
      .clk(clk), .rst_n(rst_n), .line_sol(sol),
      .in_pix(in2), .out_pix(out2), .out_half(h2),
      .wr_en_n(we2), .wr_rst_n(wr2),
      .rd_en_n(re2), .rd_rst_n(rr2), .oe_n(oe2), .tail_stale(st2));

   scan_doubler_ctl #(.NUM_BUF(1), .OUT_LINE(OL), .IN_LINE(IL), .MIN_GAP(GAP)) i_scan_doubler_ctl_one (
      .clk(clk), .rst_n(rst_n), .line_sol(sol),
      .in_pix(in1), .out_pix(out1), .out_half(h1),
      .wr_en_n(we1), .wr_rst_n(wr1),
      .rd_en_n(re1), .rd_rst_n(rr1), .oe_n(oe1), .tail_stale(st1));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // k: cycles since line start; expected out_pix, half, wr_en_n, wr_rst_n, stale
   typedef struct packed {
      logic [7:0] k;
      logic [7:0] op;
      logic       hf;
      logic       wen;
      logic       wrst;
      logic       stl;
   } vec_t;

   localparam vec_t TBL [10] = '{
      '{8'd0,  8'd0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'd1,  8'd1, 1'b0, 1'b1, 1'b1, 1'b0},
      '{8'd4,  8'd4, 1'b0, 1'b0, 1'b1, 1'b0},
      '{8'd5,  8'd5, 1'b0, 1'b1, 1'b1, 1'b0},
      '{8'd9,  8'd9, 1'b0, 1'b1, 1'b1, 1'b0},
      '{8'd10, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'd14, 8'd4, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'd15, 8'd5, 1'b1, 1'b1, 1'b1, 1'b1},
      '{8'd18, 8'd8, 1'b1, 1'b0, 1'b1, 1'b1},
      '{8'd19, 8'd9, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
   end

   initial begin
      int idx;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: idle until the first line start
      chk("R1 wr_en_n", we2, 1);
      chk("R1 wr_rst_n", wr2, 1);
      chk("R1 rd_en_n", re2, 3);
      chk("R1 oe_n", oe2, 3);
      chk("R1 single rd_en_n", re1, 1);
      chk("R1 in_pix", in2, 0);
      chk("R1 out_pix", out2, 0);
      chk("R1 tail_stale", st2, 0);

      sol = 1'b1;
      @(negedge clk) sol = 1'b0;
      idx = 0;
      for (int k = 0; k < IL; k++) begin
         if (idx < 10 && int'(TBL[idx].k) == k) begin
            chk("R2 in_pix", in2, k);
            chk("R3 out_pix", out2, int'(TBL[idx].op));
            chk("R3 out_half", h2, TBL[idx].hf);
            chk("R4 wr_en_n", we2, TBL[idx].wen);
            chk("R5 wr_rst_n", wr2, TBL[idx].wrst);
            chk("R9 tail_stale", st2, TBL[idx].stl);
            chk("R8 rd_en_n", re2, TBL[idx].hf ? 1 : 2);
            chk("R8 oe_n", oe2, TBL[idx].hf ? 1 : 2);
            chk("R6 R8 rd_rst_n", rr2, (TBL[idx].op != 0) ? 3 : (TBL[idx].hf ? 1 : 2));
            chk("R7 single rd_en_n", re1, 0);
            chk("R7 single oe_n", oe1, 0);
            chk("R6 single rd_rst_n", rr1, (TBL[idx].op == 0) ? 0 : 1);
            chk("R9 single tail_stale", st1, TBL[idx].stl);
            idx++;
         end
         @(negedge clk);
      end
      // R2: natural wrap without a line-start pulse
      chk("R2 wrap in_pix", in2, 0);
      chk("R3 wrap out_half", h2, 0);
      chk("R5 wrap wr_rst_n", wr2, 0);
      chk("R8 wrap rd_en_n", re2, 2);

      // R10: mid-line restart from an odd position in the second half
      repeat (13) @(negedge clk);
      chk("R10 pre in_pix", in2, 13);
      sol = 1'b1;
      @(negedge clk) sol = 1'b0;
      chk("R10 in_pix", in2, 0);
      chk("R10 out_pix", out2, 0);
      chk("R10 out_half", h2, 0);
      chk("R10 wr_rst_n", wr2, 0);
      chk("R10 single out_pix", out1, 0);
      @(negedge clk);
      chk("R10 step in_pix", in2, 1);
      chk("R4 after restart wr_en_n", we2, 1);
      summary();
   end

endmodule